// File: doc/BRIEF.md
# Go-Back-N Frame Receiver

This block is the receive half of a point-to-point link layer. A transceiver hands it one 32-bit word per clock. The block reads the top byte of each header word to tell a data frame from an acknowledgement word. For a data frame it streams the 128-byte packet out as eight 128-bit words and checks the CRC word at the end of the packet. It then tells the companion transmitter whether to acknowledge the frame, and with which sequence number.

An acknowledgement word passes its number straight to the transmitter, which uses it to slide its send window. The packet's first byte is the destination address. It goes to an address lookup port one clock after it arrives, so the route can resolve while the rest of the packet is still streaming in. The downstream buffer receives every word of every frame. The buffer discards a frame when the drop flag is raised with that frame's last word.

Top module: `gbn_frame_rx`

## Requirements
- R1: After reset, addr_valid, out_valid, out_last, out_drop, ack_req and ack_rx_valid are all low, and the expected sequence number is 0.
- R2: While waiting for a header, a word with 0xFF in bits 31:24 opens a data frame. Its sequence number is bits [SEQ_W-1:0]. The next PKT_WORDS accepted words are the packet.
- R3: While waiting for a header, a word with 0xF0 in bits 31:24 causes a one-clock ack_rx_valid pulse in the following cycle, with ack_rx_num equal to bits [SEQ_W-1:0] of that word.
- R4: While waiting for a header, a word with any other value in bits 31:24 produces no output. The word after it is again decoded as a header.
- R5: One cycle after the first packet word is accepted, addr_valid pulses for one cycle and addr carries bits 31:24 of that word.
- R6: Every PACK accepted packet words produce one out_valid pulse in the cycle after the last word of the group. out_data holds the earliest word of the group in its top 32 bits. out_last marks the final group of the packet.
- R7: The CRC is CRC-32 with polynomial 0x04C11DB7. It is computed MSB first over the first PKT_WORDS-1 packet words, starts from 0xFFFFFFFF, uses no reflection and no final inversion, and must equal the last packet word.
- R8: A frame with a good CRC whose number equals the expected number gives ack_req with ack_num equal to that number, together with out_last, and out_drop stays low. The expected number then advances modulo 2^SEQ_W.
- R9: A frame with a bad CRC raises out_drop with out_last. It gives no ack_req and leaves the expected number unchanged.
- R10: A frame with a good CRC but the wrong number raises out_drop. It gives ack_req with ack_num equal to the expected number minus 1, modulo 2^SEQ_W, and leaves the expected number unchanged.
- R11: A cycle with in_valid low changes no state, whatever in_data holds. A frame with idle gaps gives the same results as one without gaps.
- R12: Packet words are never decoded as headers, even when they carry 0xFF or 0xF0 in bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_data holds a word this cycle |
| in_data | input | 32 | Word from the transceiver |
| addr_valid | output | 1 | Destination address is valid (one-cycle pulse) |
| addr | output | 8 | Destination address for the lookup |
| out_valid | output | 1 | out_data holds a packed word |
| out_data | output | 32*PACK | Packed packet word |
| out_last | output | 1 | Final packed word of a packet |
| out_drop | output | 1 | The packet ending now must be discarded |
| ack_req | output | 1 | Transmitter should send an acknowledgement |
| ack_num | output | SEQ_W | Number to acknowledge |
| ack_rx_valid | output | 1 | An acknowledgement word arrived |
| ack_rx_num | output | SEQ_W | Number carried by that acknowledgement |

## Verification
Every result is registered off the edge that accepts the word that causes it. That word is the first packet word for the address, the last word of each group for out_valid, the CRC word for out_drop and ack_req, and the acknowledgement word for ack_rx_valid. Each result is therefore visible in the cycle right after that edge. The bench records the cycle of each edge that takes a word and the cycle of each output event. It requires the two cycle numbers to be equal, so a result that comes one clock early or one clock late fails just as a wrong value does. The bench sweeps every sequence number, every acknowledgement number and a set of unknown marker bytes, and it repeats frames with idle gaps that carry 0xFF headers.

// File: rtl/gbnrx_pkg.sv
package gbnrx_pkg;
  localparam logic [7:0]  MARK_DATA = 8'hFF;
  localparam logic [7:0]  MARK_ACK  = 8'hF0;
  localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;

  typedef enum logic {ST_HUNT, ST_BODY} rx_state_e;

  // Folds one 32-bit word into the CRC, most significant bit first.
  function automatic logic [31:0] crc32_word(input logic [31:0] crc, input logic [31:0] data);
    logic [31:0] c;
    c = crc;
    for (int b = 31; b >= 0; b--) begin
      if (c[31] ^ data[b]) c = (c << 1) ^ CRC_POLY;
      else                 c = c << 1;
    end
    return c;
  endfunction

  // Sequence number one below the given one, wrapping around.
  function automatic logic [7:0] seq_prev(input logic [7:0] s);
    return s - 8'd1;
  endfunction
endpackage

// File: rtl/gbnrx_framer.sv
module gbnrx_framer
  import gbnrx_pkg::*;
#(
  parameter int SEQ_W     = 3,
  parameter int PKT_WORDS = 32,
  parameter int PACK      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_mark,
  input  logic [SEQ_W-1:0] in_num,
  output logic             hdr_data,
  output logic             hdr_ack,
  output logic             body_beat,
  output logic             first_beat,
  output logic             last_beat,
  output logic             grp_end,
  output logic [SEQ_W-1:0] frm_seq,
  output logic             addr_valid,
  output logic [7:0]       addr
);
  localparam int CNT_W = $clog2(PKT_WORDS);
  localparam int PW    = (PACK > 1) ? $clog2(PACK) : 1;

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;

  assign hdr_data   = in_valid && (state == ST_HUNT) && (in_mark == MARK_DATA);
  assign hdr_ack    = in_valid && (state == ST_HUNT) && (in_mark == MARK_ACK);
  assign body_beat  = in_valid && (state == ST_BODY);
  assign first_beat = body_beat && (cnt == '0);
  assign last_beat  = body_beat && (cnt == CNT_W'(PKT_WORDS - 1));

  generate
    if (PACK > 1) begin : g_grp
      assign grp_end = body_beat && (&cnt[PW-1:0]);
    end else begin : g_single
      assign grp_end = body_beat;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      cnt        <= '0;
      frm_seq    <= '0;
      addr_valid <= 1'b0;
      addr       <= '0;
    end else begin
      addr_valid <= first_beat;
      if (first_beat) addr <= in_mark;
      if (hdr_data) begin
        state   <= ST_BODY;
        cnt     <= '0;
        frm_seq <= in_num;
      end else if (body_beat) begin
        cnt <= cnt + 1'b1;
        if (last_beat) state <= ST_HUNT;
      end
    end
  end
endmodule

// File: rtl/gbnrx_crc.sv
module gbnrx_crc
  import gbnrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        body_beat,
  input  logic        first_beat,
  input  logic        last_beat,
  input  logic [31:0] in_data,
  output logic        crc_ok
);
  logic [31:0] crc_q;

  assign crc_ok = (crc_q == in_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (first_beat) begin
      crc_q <= crc32_word(CRC_SEED, in_data);
    end else if (body_beat && !last_beat) begin
      crc_q <= crc32_word(crc_q, in_data);
    end
  end
endmodule

// File: rtl/gbnrx_packer.sv
module gbnrx_packer #(
  parameter int PACK = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               body_beat,
  input  logic               grp_end,
  input  logic               last_beat,
  input  logic [31:0]        in_data,
  output logic               out_valid,
  output logic [32*PACK-1:0] out_data,
  output logic               out_last
);
  localparam int OUT_W  = 32 * PACK;
  localparam int HOLD_W = (PACK > 1) ? 32 * (PACK - 1) : 32;

  logic [OUT_W-1:0] packed_w;

  generate
    if (PACK > 1) begin : g_hold
      logic [HOLD_W-1:0] hold;
      assign packed_w = {hold, in_data};
      always_ff @(posedge clk) begin
        if (!rst_n) hold <= '0;
        else if (body_beat) begin
          if (PACK > 2) hold <= HOLD_W'({hold, in_data});
          else          hold <= HOLD_W'(in_data);
        end
      end
    end else begin : g_pass
      assign packed_w = in_data;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= grp_end;
      out_last  <= last_beat;
      if (grp_end) out_data <= packed_w;
    end
  end
endmodule

// File: rtl/gbnrx_seq.sv
module gbnrx_seq
  import gbnrx_pkg::*;
#(
  parameter int SEQ_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             last_beat,
  input  logic             crc_ok,
  input  logic [SEQ_W-1:0] frm_seq,
  input  logic             hdr_ack,
  input  logic [SEQ_W-1:0] in_num,
  output logic             ack_req,
  output logic [SEQ_W-1:0] ack_num,
  output logic             out_drop,
  output logic             ack_rx_valid,
  output logic [SEQ_W-1:0] ack_rx_num,
  output logic [SEQ_W-1:0] exp_seq
);
  logic in_order;
  logic accept;
  logic [SEQ_W-1:0] reack_num;

  assign in_order  = (frm_seq == exp_seq);
  assign accept    = last_beat && crc_ok && in_order;
  assign reack_num = SEQ_W'(seq_prev(8'(exp_seq)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_req      <= 1'b0;
      ack_num      <= '0;
      out_drop     <= 1'b0;
      ack_rx_valid <= 1'b0;
      ack_rx_num   <= '0;
      exp_seq      <= '0;
    end else begin
      ack_req      <= last_beat && crc_ok;
      out_drop     <= last_beat && !accept;
      ack_rx_valid <= hdr_ack;
      if (hdr_ack) ack_rx_num <= in_num;
      if (last_beat && crc_ok) ack_num <= in_order ? frm_seq : reack_num;
      if (accept) exp_seq <= exp_seq + 1'b1;
    end
  end
endmodule

// File: rtl/gbn_frame_rx.sv
module gbn_frame_rx #(
  parameter int SEQ_W     = 3,
  parameter int PKT_WORDS = 32,
  parameter int PACK      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [31:0]        in_data,
  output logic               addr_valid,
  output logic [7:0]         addr,
  output logic               out_valid,
  output logic [32*PACK-1:0] out_data,
  output logic               out_last,
  output logic               out_drop,
  output logic               ack_req,
  output logic [SEQ_W-1:0]   ack_num,
  output logic               ack_rx_valid,
  output logic [SEQ_W-1:0]   ack_rx_num
);
  logic             hdr_data, hdr_ack, body_beat, first_beat, last_beat, grp_end;
  logic             crc_ok;
  logic [SEQ_W-1:0] frm_seq, exp_seq;

  gbnrx_framer #(.SEQ_W(SEQ_W), .PKT_WORDS(PKT_WORDS), .PACK(PACK)) u_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_mark(in_data[31:24]), .in_num(in_data[SEQ_W-1:0]),
    .hdr_data(hdr_data), .hdr_ack(hdr_ack), .body_beat(body_beat),
    .first_beat(first_beat), .last_beat(last_beat), .grp_end(grp_end),
    .frm_seq(frm_seq), .addr_valid(addr_valid), .addr(addr)
  );

  gbnrx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .body_beat(body_beat), .first_beat(first_beat),
    .last_beat(last_beat), .in_data(in_data), .crc_ok(crc_ok)
  );

  gbnrx_packer #(.PACK(PACK)) u_packer (
    .clk(clk), .rst_n(rst_n), .body_beat(body_beat), .grp_end(grp_end),
    .last_beat(last_beat), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  gbnrx_seq #(.SEQ_W(SEQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .last_beat(last_beat), .crc_ok(crc_ok),
    .frm_seq(frm_seq), .hdr_ack(hdr_ack), .in_num(in_data[SEQ_W-1:0]),
    .ack_req(ack_req), .ack_num(ack_num), .out_drop(out_drop),
    .ack_rx_valid(ack_rx_valid), .ack_rx_num(ack_rx_num), .exp_seq(exp_seq)
  );
endmodule

// File: rtl/gbnrx_chk.sv
module gbnrx_chk #(
  parameter int SEQ_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_data,
  input logic             addr_valid,
  input logic             out_valid,
  input logic             out_last,
  input logic             out_drop,
  input logic             ack_req,
  input logic             ack_rx_valid,
  input logic [SEQ_W-1:0] exp_seq
);
  // R5
  addr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> !addr_valid);

  // R6
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R12
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_req && ack_rx_valid));

  // R8
  ack_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> out_last);

  // R8
  good_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && !out_drop) |-> ack_req);

  // R9
  exp_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_seq != $past(exp_seq)) |-> (ack_req && !out_drop));

  // R2
  no_hdr_in_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> !$past(hdr_data));
endmodule

bind gbn_frame_rx gbnrx_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_data(hdr_data), .addr_valid(addr_valid),
  .out_valid(out_valid), .out_last(out_last), .out_drop(out_drop),
  .ack_req(ack_req), .ack_rx_valid(ack_rx_valid), .exp_seq(exp_seq)
);

// File: tb/gbn_frame_rx_test.sv
module gbn_frame_rx_test;
  localparam int SEQ_W = 3;
  localparam int NW    = 32;
  localparam int PACK  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic addr_valid, out_valid, out_last, out_drop, ack_req, ack_rx_valid;
  logic [7:0] addr;
  logic [127:0] out_data;
  logic [SEQ_W-1:0] ack_num, ack_rx_num;

  gbn_frame_rx #(.SEQ_W(SEQ_W), .PKT_WORDS(NW), .PACK(PACK)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .addr_valid(addr_valid), .addr(addr), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_drop(out_drop), .ack_req(ack_req), .ack_num(ack_num),
    .ack_rx_valid(ack_rx_valid), .ack_rx_num(ack_rx_num)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Monitor, sampled 1 ns after each rising edge.
  logic [127:0] ow [16];
  int ocyc [16];
  bit olast [16];
  bit odrop [16];
  int ow_n = 0, a_n = 0, a_cyc = 0, k_n = 0, k_cyc = 0, r_n = 0, r_cyc = 0;
  logic [7:0] a_val;
  logic [SEQ_W-1:0] k_num, r_num;

  always @(posedge clk) begin
    #1;
    if (out_valid && ow_n < 16) begin
      ow[ow_n] = out_data; ocyc[ow_n] = cyc; olast[ow_n] = out_last; odrop[ow_n] = out_drop;
      ow_n++;
    end
    if (addr_valid) begin a_n++; a_val = addr; a_cyc = cyc; end
    if (ack_req) begin k_n++; k_num = ack_num; k_cyc = cyc; end
    if (ack_rx_valid) begin r_n++; r_num = ack_rx_num; r_cyc = cyc; end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear();
    ow_n = 0; a_n = 0; k_n = 0; r_n = 0;
  endtask

  task automatic put(input logic [31:0] w, output int c);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; c = cyc + 1;
  endtask

  // Idle cycle carrying a data-frame marker, which must be ignored.
  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_data = 32'hFF00_0005;
  endtask

  function automatic logic [31:0] crc_bytes(input logic [31:0] w [32]);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < NW - 1; i++) begin
      for (int k = 3; k >= 0; k--) begin
        c = c ^ {w[i][8*k +: 8], 24'h0};
        for (int b = 0; b < 8; b++) c = c[31] ? ((c << 1) ^ 32'h04C1_1DB7) : (c << 1);
      end
    end
    return c;
  endfunction

  int exp_seq = 0;

  task automatic frame(input int sq, input logic [7:0] ad, input int seed, input bit bad, input bit gap);
    logic [31:0] w [32];
    int c [32];
    int hc;
    bit good, ackexp;
    int num;
    bit side_ok;
    for (int i = 0; i < NW; i++)
      w[i] = (i % 5 == 2) ? {8'hF0, 24'(seed * 131 + i)} :
             (i % 7 == 3) ? {8'hFF, 24'(i * 977 + seed)} :
             32'(seed * 32'h9E37_79B9) ^ 32'(i * 32'h0100_0193);
    w[0] = {ad, 24'(seed * 7919)};
    w[NW-1] = crc_bytes(w) ^ (bad ? 32'h0000_0100 : 32'h0);
    clear();
    put({8'hFF, 21'(seed), 3'(sq)}, hc);
    for (int i = 0; i < NW; i++) begin
      if (gap && (i % 3 == 1)) idle();
      put(w[i], c[i]);
    end
    idle();
    repeat (2) @(negedge clk);
    good   = !bad && (sq % 8 == exp_seq);
    ackexp = !bad;
    num    = good ? sq % 8 : (exp_seq + 7) % 8;
    // R6: eight packed words, each one cycle after its group's last word
    check(ow_n == 8, "R6 word count", 128'(ow_n), 128'(8));
    for (int g = 0; g < 8 && g < ow_n; g++) begin
      check(ow[g] == {w[4*g], w[4*g+1], w[4*g+2], w[4*g+3]}, "R6 packed data", ow[g],
            {w[4*g], w[4*g+1], w[4*g+2], w[4*g+3]});
      check(ocyc[g] == c[4*g+3], "R6 out timing R11", 128'(ocyc[g]), 128'(c[4*g+3]));
      check(olast[g] == (g == 7), "R6 last flag", 128'(olast[g]), 128'(g == 7));
      if (g < 7) check(!odrop[g], "R9 drop only at end", 128'(odrop[g]), 128'(0));
    end
    // R7 R8 R9 R10: drop verdict
    if (ow_n == 8) check(odrop[7] == !good, "R7 R8 R9 R10 drop", 128'(odrop[7]), 128'(!good));
    // R5: address one cycle after the first packet word
    side_ok = (a_n == 1) && (a_val == ad) && (a_cyc == c[0]);
    check(side_ok, "R5 address", {96'(a_n), 8'(a_val), 24'(a_cyc)}, {96'(1), ad, 24'(c[0])});
    // R8 R9 R10: acknowledgement request
    check(k_n == int'(ackexp), "R8 R9 ack count", 128'(k_n), 128'(ackexp));
    if (ackexp && k_n == 1) begin
      check(int'(k_num) == num, "R8 R10 ack number", 128'(k_num), 128'(num));
      check(k_cyc == c[NW-1], "R8 ack timing", 128'(k_cyc), 128'(c[NW-1]));
    end
    // R12: payload words with marker bytes are not headers
    check(r_n == 0, "R12 no ack_rx inside frame", 128'(r_n), 128'(0));
    if (good) exp_seq = (exp_seq + 1) % 8;
  endtask

  task automatic ack_word(input int n);
    int c;
    clear();
    put({8'hF0, 21'(n * 3 + 1), 3'(n)}, c);
    idle();
    repeat (2) @(negedge clk);
    // R3
    check(r_n == 1 && int'(r_num) == n && r_cyc == c, "R3 ack word",
          {96'(r_n), 8'(r_num), 24'(r_cyc)}, {96'(1), 8'(n), 24'(c)});
    check(ow_n == 0 && a_n == 0 && k_n == 0, "R3 no side effects",
          128'(ow_n + a_n + k_n), 128'(0));
  endtask

  task automatic junk_word(input logic [7:0] m);
    int c;
    clear();
    put({m, 24'h00_0001}, c);
    idle();
    repeat (2) @(negedge clk);
    // R4
    check(ow_n + a_n + k_n + r_n == 0, "R4 unknown marker ignored",
          128'(ow_n + a_n + k_n + r_n), 128'(0));
  endtask

  initial begin
    logic [7:0] junk [6];
    junk = '{8'h00, 8'h7F, 8'hFE, 8'hF1, 8'h0F, 8'hEF};
    repeat (3) @(negedge clk);
    // R1: reset state
    check({addr_valid, out_valid, out_last, out_drop, ack_req, ack_rx_valid} == 6'b0,
          "R1 reset outputs", 128'({addr_valid, out_valid, out_last, out_drop, ack_req, ack_rx_valid}), 128'(0));
    rst_n = 1'b1;
    idle();
    for (int n = 0; n < 8; n++) ack_word(n);
    for (int j = 0; j < 6; j++) junk_word(junk[j]);
    // R2 R8: every sequence number in order, with wrap
    for (int s = 0; s < 9; s++) frame(s, 8'(s * 37 + 5), s + 1, 1'b0, s[0]);
    // R9: bad CRC, expected stays 1
    frame(1, 8'hA5, 20, 1'b1, 1'b0);
    // R10: wrong number, re-ack expected-1 = 0
    frame(4, 8'h3C, 21, 1'b0, 1'b1);
    frame(1, 8'h11, 22, 1'b0, 1'b0);
    // R10 with bad CRC: no ack
    frame(6, 8'h22, 23, 1'b1, 1'b0);
    // R4: unknown marker then a frame
    junk_word(8'h55);
    frame(2, 8'hFF, 24, 1'b0, 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule